// File: doc/BRIEF.md
# Vertical Blanking Interval Line Gate

This block sits in the datapath of a composite video encoder. For every sample it decides whether the incoming digitized YCbCr sample goes on to the encoder unchanged or is replaced by the blanking code. The decision depends on the line number, the field, which half of the line is current, the television standard (525 lines at 60 Hz or 625 lines at 50 Hz) and a blanking mode bit.

With the mode bit clear, the whole vertical blanking interval (VBI) is blanked. With it set, the block works in partial blanking. In this mode, VBI lines that carry no line sync and no equalizing pulses pass their samples through. This lets ancillary data that rides in the digital stream, such as widescreen signalling, copy management or program data, reach the encoded output.

Line counting and sync generation happen upstream. The standard select and the mode bit are captured only on the line-start cycle, so a setting never changes partway through a line. The output is registered and has a latency of one cycle.

Top module: `vbi_line_gate`

## Requirements
- R1: While reset is asserted and after it is released, until the first clock edge, `pass_o` is 0 and the outputs hold the blanking codes. The captured settings reset to 525-line standard and full blanking.
- R2: A blanked sample is output as luma 16 and both chroma components 128, each shifted left by DATA_W-8 bits.
- R3: A line outside the VBI passes its sample unchanged, whatever the value of the mode bit.
- R4: With `partial_mode` = 0, every VBI line is blanked. Field 0 is the first field and line numbers start at 1. For `std_625` = 0, the VBI is line 525 or lines 1 to 21 in field 0, and lines 262 to 284 in field 1. For `std_625` = 1, it is lines 624 to 625 or 1 to 22 in field 0, and lines 311 to 335 in field 1.
- R5: In partial mode with the 525-line standard, samples pass on lines 10 to 21 of field 0 and on lines 274 to 284 of field 1.
- R6: In partial mode with the 625-line standard, samples pass on lines 7 to 22 of field 0 and on lines 319 to 335 of field 1.
- R7: In partial mode with the 525-line standard, line 273 of field 1 passes only while `second_half` = 1. With `second_half` = 0 it is blanked.
- R8: VBI lines that carry sync or equalizing pulses are blanked in both modes. Examples are lines 1 to 6 of field 0 and lines 262 to 272 of field 1 in the 525-line standard.
- R9: `std_625` and `partial_mode` take effect on a cycle where `line_start` = 1, starting with that cycle. On other cycles, changes to them have no effect until the next line start.
- R10: `pass_o`, `y_o`, `cb_o` and `cr_o` reflect the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Marks the first sample of a line; settings are captured here |
| line_num | input | LINE_W | Current line number within the frame, starting at 1 |
| field | input | 1 | 0 = first field, 1 = second field |
| second_half | input | 1 | 1 while the second half of the line is current |
| std_625 | input | 1 | 0 = 525/60, 1 = 625/50 |
| partial_mode | input | 1 | 0 = blank the whole VBI, 1 = partial blanking |
| y_in | input | DATA_W | Incoming luma sample |
| cb_in | input | DATA_W | Incoming blue-difference sample |
| cr_in | input | DATA_W | Incoming red-difference sample |
| pass_o | output | 1 | 1 = sample passed, 0 = blanked |
| y_o | output | DATA_W | Outgoing luma |
| cb_o | output | DATA_W | Outgoing blue-difference |
| cr_o | output | DATA_W | Outgoing red-difference |

## Verification
A wrong window bound, or a range check that does not wrap, shows at the ports as a single line that is blanked or passed wrongly. It appears one cycle after that line number is applied, so the bench probes each boundary line and its neighbour on either side. A settings register that updates without a line start, or that fails to update on one, leaves the output decision wrong for the rest of that line. The bench detects this from the first sample after the change.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;

   localparam int NUM_STD = 2;   // index 0: 525/60, index 1: 625/50
   localparam int MIN_DATA_W = 8;
   localparam int MIN_LINE_W = 10;

   // One field's window description; ranges may wrap past the last line.
   typedef struct packed {
      int   vbi_lo;
      int   vbi_hi;
      int   open_lo;
      int   open_hi;
      logic half_at_lo;   // open_lo line opens only in its second half
   } win_t;

   function automatic win_t window_of(input logic is625, input logic fld);
      win_t w;
      w.half_at_lo = 1'b0;
      if (!is625) begin
         if (!fld) begin
            w.vbi_lo = 525; w.vbi_hi = 21; w.open_lo = 10;  w.open_hi = 21;
         end else begin
            w.vbi_lo = 262; w.vbi_hi = 284; w.open_lo = 273; w.open_hi = 284;
            w.half_at_lo = 1'b1;
         end
      end else begin
         if (!fld) begin
            w.vbi_lo = 624; w.vbi_hi = 22;  w.open_lo = 7;   w.open_hi = 22;
         end else begin
            w.vbi_lo = 311; w.vbi_hi = 335; w.open_lo = 319; w.open_hi = 335;
         end
      end
      return w;
   endfunction

   // Inclusive range test that wraps when lo > hi.
   function automatic logic in_wrap(input int v, input int lo, input int hi);
      if (lo <= hi) return (v >= lo) && (v <= hi);
      else          return (v >= lo) || (v <= hi);
   endfunction

endpackage

// File: rtl/vbi_mode_latch.sv
module vbi_mode_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic std_in,
   input  logic partial_in,
   output logic std_eff,
   output logic partial_eff,
   output logic std_q,
   output logic partial_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_q     <= 1'b0;
         partial_q <= 1'b0;
      end else if (line_start) begin
         std_q     <= std_in;
         partial_q <= partial_in;
      end
   end

   // The line-start cycle already uses the newly presented settings.
   assign std_eff     = line_start ? std_in     : std_q;
   assign partial_eff = line_start ? partial_in : partial_q;

endmodule

// File: rtl/vbi_window_decode.sv
module vbi_window_decode
   import vbi_gate_pkg::*;
#(
   parameter int LINE_W = 10
) (
   input  logic [LINE_W-1:0] line_num,
   input  logic              field,
   input  logic              second_half,
   input  logic              std_sel,
   output logic              in_vbi,
   output logic              is_open
);

   logic [NUM_STD-1:0] vbi_g;
   logic [NUM_STD-1:0] open_g;
   int                 line_i;

   assign line_i = int'(line_num);

   for (genvar g = 0; g < NUM_STD; g++) begin : g_std
      localparam win_t W_F0 = window_of(g == 1, 1'b0);
      localparam win_t W_F1 = window_of(g == 1, 1'b1);
      win_t w;
      always_comb begin
         w         = field ? W_F1 : W_F0;
         vbi_g[g]  = in_wrap(line_i, w.vbi_lo, w.vbi_hi);
         open_g[g] = in_wrap(line_i, w.open_lo, w.open_hi)
                     && !(w.half_at_lo && (line_i == w.open_lo) && !second_half);
      end
   end

   assign in_vbi  = vbi_g[std_sel];
   assign is_open = open_g[std_sel];

endmodule

// File: rtl/vbi_sample_mux.sv
module vbi_sample_mux #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pass_d,
   input  logic [DATA_W-1:0] y_in,
   input  logic [DATA_W-1:0] cb_in,
   input  logic [DATA_W-1:0] cr_in,
   output logic              pass_o,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] cb_o,
   output logic [DATA_W-1:0] cr_o
);

   localparam int SHIFT = DATA_W - 8;
   localparam logic [DATA_W-1:0] BLANK_Y = DATA_W'(16)  << SHIFT;
   localparam logic [DATA_W-1:0] BLANK_C = DATA_W'(128) << SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_o <= 1'b0;
         y_o    <= BLANK_Y;
         cb_o   <= BLANK_C;
         cr_o   <= BLANK_C;
      end else begin
         pass_o <= pass_d;
         y_o    <= pass_d ? y_in  : BLANK_Y;
         cb_o   <= pass_d ? cb_in : BLANK_C;
         cr_o   <= pass_d ? cr_in : BLANK_C;
      end
   end

endmodule

// File: rtl/vbi_line_gate.sv
module vbi_line_gate
   import vbi_gate_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [LINE_W-1:0] line_num,
   input  logic              field,
   input  logic              second_half,
   input  logic              std_625,
   input  logic              partial_mode,
   input  logic [DATA_W-1:0] y_in,
   input  logic [DATA_W-1:0] cb_in,
   input  logic [DATA_W-1:0] cr_in,
   output logic              pass_o,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] cb_o,
   output logic [DATA_W-1:0] cr_o
);

   if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
      $error("vbi_line_gate: DATA_W must be at least 8");
   end
   if (LINE_W < MIN_LINE_W) begin : g_bad_line_w
      $error("vbi_line_gate: LINE_W must hold line 625");
   end

   logic std_eff, partial_eff, std_q, partial_q;
   logic in_vbi, is_open, pass_d;

   vbi_mode_latch u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_start  (line_start),
      .std_in      (std_625),
      .partial_in  (partial_mode),
      .std_eff     (std_eff),
      .partial_eff (partial_eff),
      .std_q       (std_q),
      .partial_q   (partial_q)
   );

   vbi_window_decode #(.LINE_W(LINE_W)) u_decode (
      .line_num    (line_num),
      .field       (field),
      .second_half (second_half),
      .std_sel     (std_eff),
      .in_vbi      (in_vbi),
      .is_open     (is_open)
   );

   assign pass_d = !in_vbi || (partial_eff && is_open);

   vbi_sample_mux #(.DATA_W(DATA_W)) u_mux (
      .clk    (clk),
      .rst_n  (rst_n),
      .pass_d (pass_d),
      .y_in   (y_in),
      .cb_in  (cb_in),
      .cr_in  (cr_in),
      .pass_o (pass_o),
      .y_o    (y_o),
      .cb_o   (cb_o),
      .cr_o   (cr_o)
   );

endmodule

// File: rtl/vbi_line_gate_chk.sv
module vbi_line_gate_chk #(
   parameter int DATA_W = 8,
   parameter int LINE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_start,
   input logic [LINE_W-1:0] line_num,
   input logic              field,
   input logic              std_q,
   input logic              partial_q,
   input logic [DATA_W-1:0] y_in,
   input logic [DATA_W-1:0] cb_in,
   input logic [DATA_W-1:0] cr_in,
   input logic              pass_o,
   input logic [DATA_W-1:0] y_o,
   input logic [DATA_W-1:0] cb_o,
   input logic [DATA_W-1:0] cr_o
);

   localparam logic [DATA_W-1:0] CHK_Y = DATA_W'(16)  << (DATA_W - 8);
   localparam logic [DATA_W-1:0] CHK_C = DATA_W'(128) << (DATA_W - 8);

   // R2: a blanked sample carries the blanking codes
   a_r2_blank_codes: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_o |-> (y_o == CHK_Y) && (cb_o == CHK_C) && (cr_o == CHK_C));

   // R10: a passed sample equals the input from one cycle earlier
   a_r10_pass_latency: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> (y_o == $past(y_in)) && (cb_o == $past(cb_in)) && (cr_o == $past(cr_in)));

   // R3: mid-frame active lines always pass
   a_r3_active_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (line_num >= LINE_W'(40)) && (line_num <= LINE_W'(250)) |=> pass_o);

   // R8: early sync-bearing lines of field 0 are blanked in any mode
   a_r8_sync_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !field && (line_num >= LINE_W'(1)) && (line_num <= LINE_W'(6)) |=> !pass_o);

   // R9: captured settings hold between line starts
   a_r9_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(partial_q) && $stable(std_q));

endmodule

bind vbi_line_gate vbi_line_gate_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_start (line_start),
   .line_num   (line_num),
   .field      (field),
   .std_q      (std_q),
   .partial_q  (partial_q),
   .y_in       (y_in),
   .cb_in      (cb_in),
   .cr_in      (cr_in),
   .pass_o     (pass_o),
   .y_o        (y_o),
   .cb_o       (cb_o),
   .cr_o       (cr_o)
);

// File: tb/vbi_line_gate_tb_top.sv
module vbi_line_gate_tb_top;

   localparam int DW = 8;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ls = 1'b0;
   logic [LW-1:0] ln = '0;
   logic          fld = 1'b0;
   logic          half = 1'b0;
   logic          std = 1'b0;
   logic          part = 1'b0;
   logic [DW-1:0] y = '0, cb = '0, cr = '0;
   logic          pass_o;
   logic [DW-1:0] y_o, cb_o, cr_o;

   int total = 0;
   int bad = 0;
   int seed = 0;

   always #5 clk = ~clk;

   vbi_line_gate #(.DATA_W(DW), .LINE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_start(ls), .line_num(ln), .field(fld),
      .second_half(half), .std_625(std), .partial_mode(part),
      .y_in(y), .cb_in(cb), .cr_in(cr),
      .pass_o(pass_o), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
   );

   task automatic check(input string req, input logic exp_pass,
                        input logic [DW-1:0] ey, input logic [DW-1:0] ecb,
                        input logic [DW-1:0] ecr);
      total++;
      if (pass_o !== exp_pass || y_o !== ey || cb_o !== ecb || cr_o !== ecr) begin
         bad++;
         $display("FAIL %s: got pass=%0b y=%0d cb=%0d cr=%0d, want pass=%0b y=%0d cb=%0d cr=%0d",
                  req, pass_o, y_o, cb_o, cr_o, exp_pass, ey, ecb, ecr);
      end
   endtask

   // Drive one sample at the falling edge, check the result one edge later.
   task automatic apply(input int l, input logic f, input logic h, input logic s,
                        input logic m, input logic start, input logic exp_pass,
                        input string req);
      logic [DW-1:0] sy, scb, scr;
      seed++;
      sy  = DW'(8'h30 + seed);
      scb = DW'(8'h60 + 3 * seed);
      scr = DW'(8'h90 + 5 * seed);
      ln = LW'(l); fld = f; half = h; std = s; part = m; ls = start;
      y = sy; cb = scb; cr = scr;
      @(posedge clk);
      @(negedge clk);
      ls = 1'b0;
      if (exp_pass) check(req, 1'b1, sy, scb, scr);
      else          check(req, 1'b0, DW'(16), DW'(128), DW'(128));
   endtask

   task automatic t_reset;
      check("R1 reset", 1'b0, DW'(16), DW'(128), DW'(128));
      rst_n = 1'b1;
      @(negedge clk);
      // Reset settings: 525 standard, full blanking -> line 15 field 0 blanked.
      apply(15, 0, 0, 0, 1, 0, 0, "R1 reset settings");
   endtask

   task automatic t_active;
      apply(100, 0, 0, 0, 0, 1, 1, "R3 525 active mode0");
      apply(100, 1, 0, 0, 1, 1, 1, "R3 525 active mode1");
      apply(400, 1, 0, 1, 0, 1, 1, "R3 625 active field1");
      apply(524, 0, 0, 0, 0, 1, 1, "R3 525 line 524 outside wrap");
      apply(623, 0, 0, 1, 0, 1, 1, "R3 625 line 623 outside wrap");
      apply(23, 0, 0, 1, 0, 1, 1, "R3 625 line 23 after VBI");
      apply(285, 1, 0, 0, 1, 1, 1, "R3 525 line 285 after VBI");
      apply(336, 1, 0, 1, 1, 1, 1, "R3 625 line 336 after VBI");
   endtask

   task automatic t_full_blank;
      apply(525, 0, 0, 0, 0, 1, 0, "R4 525 line 525 wrap");
      apply(15, 0, 0, 0, 0, 1, 0, "R4 525 line 15");
      apply(262, 1, 0, 0, 0, 1, 0, "R4 525 line 262");
      apply(280, 1, 1, 0, 0, 1, 0, "R4 525 line 280");
      apply(624, 0, 0, 1, 0, 1, 0, "R4 625 line 624 wrap");
      apply(22, 0, 0, 1, 0, 1, 0, "R4 625 line 22");
      apply(320, 1, 0, 1, 0, 1, 0, "R4 625 line 320");
   endtask

   task automatic t_partial;
      apply(9, 0, 0, 0, 1, 1, 0, "R8 525 line 9 sync");
      apply(10, 0, 0, 0, 1, 1, 1, "R5 525 line 10");
      apply(21, 0, 0, 0, 1, 1, 1, "R5 525 line 21");
      apply(525, 0, 0, 0, 1, 1, 0, "R8 525 line 525");
      apply(272, 1, 1, 0, 1, 1, 0, "R8 525 line 272");
      apply(274, 1, 0, 0, 1, 1, 1, "R5 525 line 274");
      apply(284, 1, 0, 0, 1, 1, 1, "R5 525 line 284");
      apply(6, 0, 0, 1, 1, 1, 0, "R8 625 line 6");
      apply(7, 0, 0, 1, 1, 1, 1, "R6 625 line 7");
      apply(22, 0, 0, 1, 1, 1, 1, "R6 625 line 22");
      apply(318, 1, 0, 1, 1, 1, 0, "R8 625 line 318");
      apply(319, 1, 0, 1, 1, 1, 1, "R6 625 line 319");
      apply(335, 1, 0, 1, 1, 1, 1, "R6 625 line 335");
   endtask

   task automatic t_half_line;
      apply(273, 1, 0, 0, 1, 1, 0, "R7 line 273 first half");
      apply(273, 1, 1, 0, 1, 0, 1, "R7 line 273 second half");
      apply(273, 1, 0, 0, 1, 0, 0, "R7 line 273 back to first half");
   endtask

   task automatic t_sampling;
      apply(15, 0, 0, 0, 0, 1, 0, "R9 capture full blank");
      apply(15, 0, 0, 0, 1, 0, 0, "R9 mode change ignored mid-line");
      apply(15, 0, 0, 0, 1, 1, 1, "R9 mode taken at line start");
      apply(15, 0, 0, 0, 0, 0, 1, "R9 mode clear ignored mid-line");
      apply(22, 0, 0, 0, 0, 1, 1, "R9 capture 525 line 22");
      apply(22, 0, 0, 1, 0, 0, 1, "R9 standard change ignored mid-line");
      apply(22, 0, 0, 1, 0, 1, 0, "R9 standard taken at line start");
   endtask

   task automatic t_latency;
      logic [DW-1:0] prev;
      ln = LW'(100); fld = 0; std = 0; part = 0; ls = 1'b1;
      y = 8'h11; cb = 8'h22; cr = 8'h33;
      @(posedge clk);
      @(negedge clk);
      ls = 1'b0;
      prev = y;
      for (int i = 0; i < 6; i++) begin
         y = DW'(8'hC0 + i); cb = DW'(8'h50 + i); cr = DW'(8'hA0 + i);
         total++;
         if (y_o !== prev) begin
            bad++;
            $display("FAIL R10 latency step %0d: got y=%0d want y=%0d", i, y_o, prev);
         end
         prev = y;
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_active();
      t_full_blank();
      t_partial();
      t_half_line();
      t_sampling();
      t_latency();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule